// File: doc/BRIEF.md
# Host Address Remapper for a Four-Plane Video Memory

This block turns a byte address from the host bus, taken from inside the graphics memory window, into a word address for one plane of a four-plane video memory. First it cuts the host address down to the size of the selected window. Then an eight-way multiplexer picks the source of address bit 0. Finally the result can be limited to the first bank of 16K words. The plane address is scaled by four to form a plane-group address. That address is compared against the installed memory size, and any access at or past that size is flagged for discard.

The window select field uses the following encoding. Code 0 is a 128 KB window at segment A000. Code 1 is a 64 KB window at A000. Code 2 is a 32 KB window at B000. Code 3 is a 32 KB window at B800.

The multiplexer select is a 3-bit value built from three inputs. Bit 2 is set when the window is the 128 KB map. Bit 1 is the odd/even mode bit. Bit 0 is set when only 64 KB of memory is installed.

The logic between input and output is purely combinational. A single register stage holds the outputs, and they are valid one cycle after the host strobe.

Top module: `host_addr_remap`

## Requirements
- R1: While reset is asserted, and up to the first strobe after it, `rsp_valid`, `plane_addr`, `group_addr` and `access_ok` are all zero.
- R2: `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` is high. In cycles where no strobe was given, the other outputs hold their last values.
- R3: Window masking depends on `map_sel`.
  - Codes 0 and 1 keep host bits 15:0.
  - Codes 2 and 3 keep host bits 14:0, so plane address bit 15 is zero.
  - Bit 0 may then be replaced as described in R4 to R6.
- R4: The multiplexer select is {`map_sel`==0, `odd_even`, `mem_64k`}. For select values 0, 1, 4, 5 and 7, plane address bit 0 equals the masked host bit 0.
- R5: For select value 2, plane address bit 0 is the inverse of `page_sel`. A `page_sel` of 1 therefore picks the low 64 KB.
- R6: For select value 3, plane address bit 0 is host address bit 14. For select value 6, it is host address bit 16. Both bits are taken from the host address before masking.
- R7: When `ext_mem` is 0, the plane address is ANDed with 0x3FFF, which keeps only the first 16K words.
- R8: `group_addr` equals `plane_addr` multiplied by four.
- R9: `access_ok` is 1 exactly when `group_addr` is less than `mem_limit`. Otherwise the access is to be discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host strobe; captures the translation |
| host_addr | input | 20 | Host byte address |
| map_sel | input | 2 | Window select (0: 128K A000, 1: 64K A000, 2: 32K B000, 3: 32K B800) |
| odd_even | input | 1 | Odd/even addressing mode enable |
| page_sel | input | 1 | Page select bit; 1 picks the low 64 KB in odd/even mode |
| mem_64k | input | 1 | Set when only 64 KB of memory is installed |
| ext_mem | input | 1 | Extended memory enable; 0 limits the result to 16K words |
| mem_limit | input | 19 | Installed memory size in bytes |
| rsp_valid | output | 1 | Result valid, one cycle after the strobe |
| plane_addr | output | 16 | Per-plane word address |
| group_addr | output | 18 | Plane-group address (plane address times four) |
| access_ok | output | 1 | 1 if the group address lies below the installed size |

## Verification
Every combination of window code, odd/even mode, page select, memory size and extended-memory bit is tried against a set of host addresses. Each address pattern sets or clears bits 0, 14, 15 and 16 in its own way, so that a wrong source for bit 0, a mask one bit too wide, or a missed bank limit each gives a different plane address. Two installed sizes, 64 KB and 256 KB, exercise both outcomes of the limit compare. A dedicated pair of accesses, one just below the limit and one exactly at it, checks the edge of the compare. Cycles without a strobe, with the inputs changed, show that the outputs hold.

// File: rtl/host_remap_pkg.sv
package host_remap_pkg;

    // Window select codes
    typedef enum logic [1:0] {
        MAP_A000_128K = 2'd0,
        MAP_A000_64K  = 2'd1,
        MAP_B000_32K  = 2'd2,
        MAP_B800_32K  = 2'd3
    } map_sel_e;

    // Source of plane address bit 0
    typedef enum logic [1:0] {
        LSB_KEEP  = 2'd0,
        LSB_PAGE  = 2'd1,
        LSB_ALTLO = 2'd2,
        LSB_ALTHI = 2'd3
    } lsb_src_e;

    // Decode the 3-bit multiplexer select into a bit-0 source
    function automatic lsb_src_e decode_lsb_sel(input logic [2:0] sel);
        lsb_src_e src;
        case (sel)
            3'd2:    src = LSB_PAGE;
            3'd3:    src = LSB_ALTLO;
            3'd6:    src = LSB_ALTHI;
            default: src = LSB_KEEP;
        endcase
        return src;
    endfunction

endpackage

// File: rtl/hra_window_mask.sv
module hra_window_mask #(
    parameter int HOST_AW  = 20,
    parameter int PLANE_AW = 16
) (
    input  logic [HOST_AW-1:0]  host_addr,
    input  logic [1:0]          map_sel,
    output logic [PLANE_AW-1:0] masked_addr
);
    localparam int SMALL_AW = PLANE_AW - 1;

    logic small_win;

    always_comb begin
        // codes 2 and 3 are the 32 KB windows
        small_win   = map_sel[1];
        masked_addr = host_addr[PLANE_AW-1:0];
        if (small_win) begin
            masked_addr[PLANE_AW-1:SMALL_AW] = '0;
        end
    end
endmodule

// File: rtl/hra_lsb_mux.sv
module hra_lsb_mux
    import host_remap_pkg::*;
#(
    parameter int HOST_AW    = 20,
    parameter int ALT_LO_BIT = 14,
    parameter int ALT_HI_BIT = 16
) (
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [1:0]         map_sel,
    input  logic               odd_even,
    input  logic               page_sel,
    input  logic               mem_64k,
    input  logic               lsb_in,
    output logic               lsb_out
);
    logic [2:0] mux_sel;
    lsb_src_e   src;

    always_comb begin
        mux_sel = {map_sel == MAP_A000_128K, odd_even, mem_64k};
        src     = decode_lsb_sel(mux_sel);
        case (src)
            LSB_PAGE:  lsb_out = ~page_sel;
            LSB_ALTLO: lsb_out = host_addr[ALT_LO_BIT];
            LSB_ALTHI: lsb_out = host_addr[ALT_HI_BIT];
            default:   lsb_out = lsb_in;
        endcase
    end
endmodule

// File: rtl/hra_bank_limit.sv
module hra_bank_limit #(
    parameter int PLANE_AW = 16,
    parameter int BANK_AW  = 14
) (
    input  logic [PLANE_AW-1:0] addr_in,
    input  logic                ext_mem,
    output logic [PLANE_AW-1:0] addr_out
);
    localparam int HI_W = PLANE_AW - BANK_AW;

    generate
        if (HI_W > 0) begin : g_limit
            always_comb begin
                addr_out = addr_in;
                if (!ext_mem) begin
                    addr_out[PLANE_AW-1:BANK_AW] = '0;
                end
            end
        end else begin : g_pass
            always_comb addr_out = addr_in;
        end
    endgenerate
endmodule

// File: rtl/hra_limit_cmp.sv
module hra_limit_cmp #(
    parameter int GROUP_AW = 18,
    parameter int LIMIT_AW = 19
) (
    input  logic [GROUP_AW-1:0] group_addr,
    input  logic [LIMIT_AW-1:0] mem_limit,
    output logic                in_range
);
    localparam int PAD = LIMIT_AW - GROUP_AW;

    always_comb begin
        in_range = {{PAD{1'b0}}, group_addr} < mem_limit;
    end
endmodule

// File: rtl/host_addr_remap.sv
module host_addr_remap #(
    parameter int HOST_AW    = 20,
    parameter int PLANE_AW   = 16,
    parameter int BANK_AW    = 14,
    parameter int ALT_LO_BIT = 14,
    parameter int ALT_HI_BIT = 16,
    parameter int GROUP_AW   = PLANE_AW + 2,
    parameter int LIMIT_AW   = GROUP_AW + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [HOST_AW-1:0]  host_addr,
    input  logic [1:0]          map_sel,
    input  logic                odd_even,
    input  logic                page_sel,
    input  logic                mem_64k,
    input  logic                ext_mem,
    input  logic [LIMIT_AW-1:0] mem_limit,
    output logic                rsp_valid,
    output logic [PLANE_AW-1:0] plane_addr,
    output logic [GROUP_AW-1:0] group_addr,
    output logic                access_ok
);
    typedef struct packed {
        logic                valid;
        logic [PLANE_AW-1:0] plane;
        logic [GROUP_AW-1:0] group;
        logic                ok;
    } out_state_t;

    logic [PLANE_AW-1:0] win_addr;
    logic                lsb_new;
    logic [PLANE_AW-1:0] muxed_addr;
    logic [PLANE_AW-1:0] banked_addr;
    logic [GROUP_AW-1:0] scaled_addr;
    logic                in_range;
    out_state_t          st_d, st_q;

    hra_window_mask #(.HOST_AW(HOST_AW), .PLANE_AW(PLANE_AW)) u_win (
        .host_addr  (host_addr),
        .map_sel    (map_sel),
        .masked_addr(win_addr)
    );

    hra_lsb_mux #(.HOST_AW(HOST_AW), .ALT_LO_BIT(ALT_LO_BIT), .ALT_HI_BIT(ALT_HI_BIT)) u_lsb (
        .host_addr(host_addr),
        .map_sel  (map_sel),
        .odd_even (odd_even),
        .page_sel (page_sel),
        .mem_64k  (mem_64k),
        .lsb_in   (win_addr[0]),
        .lsb_out  (lsb_new)
    );

    always_comb muxed_addr = {win_addr[PLANE_AW-1:1], lsb_new};

    hra_bank_limit #(.PLANE_AW(PLANE_AW), .BANK_AW(BANK_AW)) u_bank (
        .addr_in (muxed_addr),
        .ext_mem (ext_mem),
        .addr_out(banked_addr)
    );

    always_comb scaled_addr = {banked_addr, 2'b00};

    hra_limit_cmp #(.GROUP_AW(GROUP_AW), .LIMIT_AW(LIMIT_AW)) u_cmp (
        .group_addr(scaled_addr),
        .mem_limit (mem_limit),
        .in_range  (in_range)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = req_valid;
        if (req_valid) begin
            st_d.plane = banked_addr;
            st_d.group = scaled_addr;
            st_d.ok    = in_range;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid  = st_q.valid;
    assign plane_addr = st_q.plane;
    assign group_addr = st_q.group;
    assign access_ok  = st_q.ok;
endmodule

// File: rtl/hra_checker.sv
module hra_checker #(
    parameter int HOST_AW  = 20,
    parameter int PLANE_AW = 16,
    parameter int BANK_AW  = 14,
    parameter int GROUP_AW = 18,
    parameter int LIMIT_AW = 19
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [HOST_AW-1:0]  host_addr,
    input logic [1:0]          map_sel,
    input logic                odd_even,
    input logic                page_sel,
    input logic                mem_64k,
    input logic                ext_mem,
    input logic [LIMIT_AW-1:0] mem_limit,
    input logic                rsp_valid,
    input logic [PLANE_AW-1:0] plane_addr,
    input logic [GROUP_AW-1:0] group_addr,
    input logic                access_ok
);
    localparam int PAD = LIMIT_AW - GROUP_AW;

    assert_valid_lag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> $stable(plane_addr) && $stable(access_ok));

    assert_small_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && $past(map_sel[1]) |-> !plane_addr[PLANE_AW-1]);

    assert_page_lsb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && $past(map_sel == 2'd1 && odd_even && !mem_64k)
        |-> plane_addr[0] == !$past(page_sel));

    assert_bank_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !$past(ext_mem) |-> plane_addr[PLANE_AW-1:BANK_AW] == '0);

    assert_scaled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        group_addr == {plane_addr, 2'b00});

    assert_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && access_ok |-> {{PAD{1'b0}}, group_addr} < $past(mem_limit));
endmodule

bind host_addr_remap hra_checker #(
    .HOST_AW(HOST_AW), .PLANE_AW(PLANE_AW), .BANK_AW(BANK_AW),
    .GROUP_AW(GROUP_AW), .LIMIT_AW(LIMIT_AW)
) u_hra_checker (.*);

// File: tb/tb_host_addr_remap.sv
`timescale 1ns/1ps
module tb_host_addr_remap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] host_addr = '0;
    logic [1:0]  map_sel = '0;
    logic        odd_even = 1'b0;
    logic        page_sel = 1'b0;
    logic        mem_64k = 1'b0;
    logic        ext_mem = 1'b0;
    logic [18:0] mem_limit = '0;
    logic        rsp_valid;
    logic [15:0] plane_addr;
    logic [17:0] group_addr;
    logic        access_ok;

    int n_checks = 0;
    int n_fails  = 0;
    logic [19:0] addrs [12];

    always #2 clk = ~clk;

    host_addr_remap dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .host_addr(host_addr),
        .map_sel(map_sel), .odd_even(odd_even), .page_sel(page_sel),
        .mem_64k(mem_64k), .ext_mem(ext_mem), .mem_limit(mem_limit),
        .rsp_valid(rsp_valid), .plane_addr(plane_addr),
        .group_addr(group_addr), .access_ok(access_ok)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic [19:0] a, input logic [1:0] m,
                                          input logic oe, input logic pg,
                                          input logic m64, input logic ext);
        logic [15:0] r;
        logic [2:0]  s;
        r = m[1] ? (a[15:0] & 16'h7FFF) : a[15:0];
        s = {m == 2'd0, oe, m64};
        if (s == 3'd2) r[0] = ~pg;
        else if (s == 3'd3) r[0] = a[14];
        else if (s == 3'd6) r[0] = a[16];
        if (!ext) r = r & 16'h3FFF;
        return r;
    endfunction

    function automatic string lsb_tag(input logic [1:0] m, input logic oe, input logic m64);
        logic [2:0] s;
        s = {m == 2'd0, oe, m64};
        if (s == 3'd2) return "R5";
        if (s == 3'd3 || s == 3'd6) return "R6";
        return "R4";
    endfunction

    task automatic do_access(input logic [19:0] a);
        logic [15:0] e;
        logic [17:0] g;
        @(negedge clk);
        host_addr = a;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        e = model(a, map_sel, odd_even, page_sel, mem_64k, ext_mem);
        g = {e, 2'b00};
        check("R2 valid", {31'd0, rsp_valid}, 32'd1);
        check(lsb_tag(map_sel, odd_even, mem_64k), {31'd0, plane_addr[0]}, {31'd0, e[0]});
        check(ext_mem ? "R3 window" : "R7 bank", {17'd0, plane_addr[15:1]}, {17'd0, e[15:1]});
        check("R8 group", {14'd0, group_addr}, {14'd0, g});
        check("R9 limit", {31'd0, access_ok}, {31'd0, ({1'b0, g} < mem_limit)});
    endtask

    initial begin
        #(4 * 150000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        addrs[0] = 20'h00000; addrs[1] = 20'hFFFFF; addrs[2] = 20'h14001;
        addrs[3] = 20'h0C000; addrs[4] = 20'h10000; addrs[5] = 20'h04000;
        addrs[6] = 20'h0BFFE; addrs[7] = 20'hA5A5A; addrs[8] = 20'h5A5A5;
        addrs[9] = 20'h08001; addrs[10] = 20'h13FFF; addrs[11] = 20'h07FFF;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", {31'd0, rsp_valid}, 32'd0);
        check("R1 plane", {16'd0, plane_addr}, 32'd0);
        check("R1 group", {14'd0, group_addr}, 32'd0);
        check("R1 ok", {31'd0, access_ok}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {16'd0, plane_addr}, 32'd0);

        // Full sweep over control combinations and address patterns
        for (int c = 0; c < 64; c++) begin
            map_sel   = c[1:0];
            odd_even  = c[2];
            page_sel  = c[3];
            mem_64k   = c[4];
            ext_mem   = c[5];
            mem_limit = c[4] ? 19'h10000 : 19'h40000;
            for (int i = 0; i < 12; i++) begin
                do_access(addrs[i]);
            end
        end

        // R2: idle cycles hold outputs while inputs change
        begin
            logic [15:0] held;
            held = plane_addr;
            host_addr = 20'h12345;
            map_sel = 2'd1;
            ext_mem = ~ext_mem;
            @(negedge clk);
            check("R2 idle valid", {31'd0, rsp_valid}, 32'd0);
            check("R2 idle hold", {16'd0, plane_addr}, {16'd0, held});
        end

        // R9: limit boundary
        map_sel = 2'd1; odd_even = 1'b0; mem_64k = 1'b0; ext_mem = 1'b1;
        mem_limit = 19'h10000;
        do_access(20'h03FFF);
        check("R9 just below", {31'd0, access_ok}, 32'd1);
        do_access(20'h04000);
        check("R9 at limit", {31'd0, access_ok}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule